// File: doc/BRIEF.md
# Bidirectional Parallel Port with Pin Sharing

This block is an 8-bit general-purpose I/O port on a simple byte-wide register bus. Software sets a latched output value and a per-pin direction. Each pin can also be handed to an alternate digital peripheral or to an analog function. For every pin the block decides three things: who drives the output buffer and its enable, whether the input buffer is on, and what a read of the data register returns. Pin inputs cross into the bus clock domain through a two-stage synchronizer before software can read them.

The analog function has the highest claim on a pin. It turns off both buffers, even when the alternate function is also enabled. The alternate function takes over only the output side. The direction bit alone still chooses the read source. An input-direction bit whose input buffer is off reads as 0. A parameter mask marks pins that are output-only; their input buffers are never enabled.

The register bus has four byte registers. Offset 0 holds data, offset 1 holds direction, offset 2 holds the alternate-function enables and offset 3 holds the analog enables. Writes take effect at the clock edge where they are presented. Read data is registered: the value for the address presented at one edge appears after that edge.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, the data, direction, alternate-enable and analog-enable registers are all 0, `pin_oe` is 0 and `bus_rdata` is 0.
- R2: A write with `bus_wr` high stores `bus_wdata` in the register at `bus_addr` (0 data, 1 direction, 2 alternate enable, 3 analog enable). Offsets 1 to 3 read back their stored value.
- R3: For a pin with direction 1 (bit value 1 = output) and neither function enabled, `pin_oe` is 1 and `pin_out` equals that pin's data bit.
- R4: A data write lands whatever the direction. When the direction is then set to output, the pin drives the most recently written value in the same cycle that `pin_oe` rises.
- R5: A direction-0 bit of a data read returns the synchronized pin input. A pin change made between edges appears in `bus_rdata` after the third rising edge: two synchronizer stages plus the registered read.
- R6: With the alternate enable set and the analog enable clear, `pin_oe` and `pin_out` follow `alt_oe` and `alt_out`. The data-register read source still follows the direction bit.
- R7: With the analog enable set, `pin_oe`, `pin_out` and `pin_ie` are 0 and `alt_in` is 0, even if the alternate enable is also set. A direction-0 bit of such a pin reads as 0; a direction-1 bit reads the data register bit.
- R8: Pins marked in parameter `OUT_ONLY` (default 8'h80, pin 7) never enable the input buffer. They read 0 when their direction is 0, and their `alt_in` is 0.
- R9: On any pin that is neither analog nor output-only, `pin_ie` is 1 and `alt_in` follows `pin_in` without delay.
- R10: `bus_rdata` after an edge shows the register selected by `bus_addr` at that edge. A data read gives the data bit for direction-1 bits and the gated synchronized input for direction-0 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pad input values |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output-buffer enables |
| pin_ie | output | 8 | Pad input-buffer enables |
| pin_ana | output | 8 | Analog function connected per pin |
| alt_out | input | 8 | Alternate peripheral output data |
| alt_oe | input | 8 | Alternate peripheral output enables |
| alt_in | output | 8 | Gated pad inputs to the alternate peripheral |

## Verification
The assertions check on every cycle that an analog pin never has a buffer on, that pins the alternate function owns follow its output enable, that output-only pins keep their input buffer off, that every write lands in the addressed register, that the synchronizer shifts one stage per edge, and that no output is enabled right after reset. Some behaviours show only over a sequence of accesses, so only the bench scenarios can show them. These are the exact three-edge latency from a pin change to read data, the glitch-free switch from input to output after a preloaded write, and the bit-by-bit read composition when direction, alternate and analog settings overlap.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned REG_ADDR_W = 2;
    localparam int unsigned REG_COUNT  = 1 << REG_ADDR_W;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_ALT  = 2'd2,
        REG_ANA  = 2'd3
    } reg_sel_e;

    // Per-pin configuration gathered from the register bank
    typedef struct packed {
        logic data;
        logic dir;
        logic alt;
        logic ana;
    } pin_cfg_t;

    // Per-pin pad controls
    typedef struct packed {
        logic oe;
        logic out;
        logic ie;
    } pad_ctl_t;

    // Ownership order: analog, then alternate digital, then the port itself
    function automatic pad_ctl_t pick_pad(input pin_cfg_t cfg,
                                          input logic     out_only,
                                          input logic     periph_oe,
                                          input logic     periph_out);
        pad_ctl_t p;
        if (cfg.ana) begin
            p.oe  = 1'b0;
            p.out = 1'b0;
            p.ie  = 1'b0;
        end else if (cfg.alt) begin
            p.oe  = periph_oe;
            p.out = periph_out;
            p.ie  = ~out_only;
        end else begin
            p.oe  = cfg.dir;
            p.out = cfg.data;
            p.ie  = ~out_only;
        end
        return p;
    endfunction

    // One read bit of the data register
    function automatic logic read_bit(input logic dir, input logic data,
                                      input logic synced, input logic ie);
        return dir ? data : (synced & ie);
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]      wdata,
    output logic [WIDTH-1:0]      data_q,
    output logic [WIDTH-1:0]      dir_q,
    output logic [WIDTH-1:0]      alt_q,
    output logic [WIDTH-1:0]      ana_q
);

    logic [WIDTH-1:0] bank [REG_COUNT];

    for (genvar r = 0; r < REG_COUNT; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[r] <= '0;
            end else if (wr && (addr == REG_ADDR_W'(r))) begin
                bank[r] <= wdata;
            end
        end

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
            (wr && addr == REG_ADDR_W'(r)) |=> (bank[r] == $past(wdata))); // R2
    end

    assign data_q = bank[REG_DATA];
    assign dir_q  = bank[REG_DIR];
    assign alt_q  = bank[REG_ALT];
    assign ana_q  = bank[REG_ANA];

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[s] <= '0;
            end else if (s == 0) begin
                stage[s] <= d;
            end else begin
                stage[s] <= stage[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q = stage[LAST];

    if (STAGES > 1) begin : g_chk
        AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (stage[LAST] == $past(stage[LAST-1]))); // R5
    end

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pkg::*;
#(
    parameter int unsigned     WIDTH    = 8,
    parameter logic [WIDTH-1:0] OUT_ONLY = 8'h80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] alt_q,
    input  logic [WIDTH-1:0] ana_q,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_ie,
    output logic [WIDTH-1:0] pin_ana,
    output logic [WIDTH-1:0] alt_in
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pin_cfg_t cfg;
        pad_ctl_t pad;

        always_comb begin
            cfg.data = data_q[i];
            cfg.dir  = dir_q[i];
            cfg.alt  = alt_q[i];
            cfg.ana  = ana_q[i];
            pad      = pick_pad(cfg, OUT_ONLY[i], alt_oe[i], alt_out[i]);
        end

        assign pin_oe[i]  = pad.oe;
        assign pin_out[i] = pad.out;
        assign pin_ie[i]  = pad.ie;
        assign alt_in[i]  = pin_in[i] & pad.ie;
        assign pin_ana[i] = ana_q[i];
    end

    AST_OUT_ONLY_NO_INPUT: assert property (@(posedge clk) disable iff (rst)
        ((pin_ie | alt_in) & OUT_ONLY) == '0); // R8

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned      WIDTH       = 8,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] OUT_ONLY    = 8'h80
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      pin_in,
    output logic [WIDTH-1:0]      pin_out,
    output logic [WIDTH-1:0]      pin_oe,
    output logic [WIDTH-1:0]      pin_ie,
    output logic [WIDTH-1:0]      pin_ana,
    input  logic [WIDTH-1:0]      alt_out,
    input  logic [WIDTH-1:0]      alt_oe,
    output logic [WIDTH-1:0]      alt_in
);

    logic [WIDTH-1:0] data_q, dir_q, alt_q, ana_q;
    logic [WIDTH-1:0] synced;
    logic [WIDTH-1:0] data_view;
    logic [WIDTH-1:0] rd_next;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .data_q (data_q),
        .dir_q  (dir_q),
        .alt_q  (alt_q),
        .ana_q  (ana_q)
    );

    gpio_pinmux #(.WIDTH(WIDTH), .OUT_ONLY(OUT_ONLY)) u_mux (
        .clk     (clk),
        .rst     (rst),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .alt_q   (alt_q),
        .ana_q   (ana_q),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_ie  (pin_ie),
        .pin_ana (pin_ana),
        .alt_in  (alt_in)
    );

    // Gating ahead of the synchronizer keeps a disabled buffer from toggling it
    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in & pin_ie),
        .q   (synced)
    );

    // Gating after it hides values captured before the buffer turned off
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            data_view[i] = read_bit(dir_q[i], data_q[i], synced[i], pin_ie[i]);
        end
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_DATA: rd_next = data_view;
            REG_DIR:  rd_next = dir_q;
            REG_ALT:  rd_next = alt_q;
            REG_ANA:  rd_next = ana_q;
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else begin
            bus_rdata <= rd_next;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && bus_rdata == '0)); // R1

    AST_ANALOG_OWNS_PIN: assert property (@(posedge clk) disable iff (rst)
        (ana_q & (pin_oe | pin_ie | pin_out | alt_in)) == '0); // R7

    AST_ALT_OWNS_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe ^ alt_oe) & alt_q & ~ana_q) == '0); // R6

    AST_DIR_READBACK: assert property (@(posedge clk) disable iff (rst)
        $past(bus_addr == REG_ADDR_W'(REG_DIR)) |-> (bus_rdata == $past(dir_q))); // R10

endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in, pin_out, pin_oe, pin_ie, pin_ana;
    logic [7:0] alt_out, alt_oe, alt_in;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_port i_gpio_port (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_ie    (pin_ie),
        .pin_ana   (pin_ana),
        .alt_out   (alt_out),
        .alt_oe    (alt_oe),
        .alt_in    (alt_in)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
        pin_in = 8'h00; alt_out = 8'h00; alt_oe = 8'h00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), v);
            check("R1 register", v, 8'h00);
        end
    endtask

    task automatic t_regs();
        logic [7:0] v;
        do_reset();
        wr_reg(2'd1, 8'hC3); wr_reg(2'd2, 8'h5A); wr_reg(2'd3, 8'h24);
        rd_reg(2'd1, v); check("R2 dir readback", v, 8'hC3);
        rd_reg(2'd2, v); check("R2 alt readback", v, 8'h5A);
        rd_reg(2'd3, v); check("R2 ana readback", v, 8'h24);
        wr_reg(2'd3, 8'h00); wr_reg(2'd2, 8'h00); wr_reg(2'd1, 8'hFF);
        wr_reg(2'd0, 8'h96);
        rd_reg(2'd0, v); check("R10 data read dir=1", v, 8'h96);
    endtask

    task automatic t_drive();
        do_reset();
        wr_reg(2'd0, 8'hA5);
        wr_reg(2'd1, 8'h0F);
        check("R3 pin_oe", pin_oe, 8'h0F);
        check("R3 pin_out", pin_out, 8'hA5);
    endtask

    task automatic t_preload();
        logic [7:0] v;
        do_reset();
        wr_reg(2'd0, 8'h3C);
        check("R4 oe still off", pin_oe, 8'h00);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'hFF;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R4 oe on", pin_oe, 8'hFF);
        check("R4 drives preload", pin_out, 8'h3C);
        rd_reg(2'd0, v); check("R4 data read", v, 8'h3C);
    endtask

    task automatic t_sync();
        do_reset();
        @(negedge clk);
        bus_addr = 2'd0; pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'hA5;
        @(negedge clk); check("R5 edge1", bus_rdata, 8'h00);
        @(negedge clk); check("R5 edge2", bus_rdata, 8'h00);
        @(negedge clk); check("R5 edge3", bus_rdata, 8'h25); // bit 7 output-only: R8
        check("R9 pin_ie", pin_ie, 8'h7F);
        check("R9 alt_in", alt_in, 8'h25);
        pin_in = 8'h5A; #1;
        check("R9 alt_in no delay", alt_in, 8'h5A);
    endtask

    task automatic t_alt();
        do_reset();
        wr_reg(2'd0, 8'hFF); wr_reg(2'd1, 8'h0F); wr_reg(2'd2, 8'hF0);
        @(negedge clk);
        alt_oe = 8'hAA; alt_out = 8'h55; pin_in = 8'h33; bus_addr = 2'd0;
        repeat (3) @(negedge clk);
        check("R6 pin_oe", pin_oe, 8'hAF);
        check("R6 pin_out", pin_out, 8'h5F);
        check("R6 read follows dir", bus_rdata, 8'h3F);
        check("R6 alt_in", alt_in, 8'h33);
    endtask

    task automatic t_analog();
        do_reset();
        wr_reg(2'd0, 8'hFF); wr_reg(2'd1, 8'h0F); wr_reg(2'd2, 8'hF0);
        wr_reg(2'd3, 8'h11);
        @(negedge clk);
        alt_oe = 8'hAA; alt_out = 8'h55; pin_in = 8'hFF; bus_addr = 2'd0;
        repeat (3) @(negedge clk);
        check("R7 pin_oe", pin_oe, 8'hAE);
        check("R7 pin_out", pin_out, 8'h4E);
        check("R7 pin_ie", pin_ie, 8'h6E);
        check("R7 alt_in", alt_in, 8'h6E);
        check("R7 pin_ana", pin_ana, 8'h11);
        check("R7 read", bus_rdata, 8'h6F);
    endtask

    task automatic t_outonly();
        logic [7:0] v;
        do_reset();
        @(negedge clk);
        pin_in = 8'h80;
        repeat (3) @(negedge clk);
        rd_reg(2'd0, v); check("R8 input read", v, 8'h00);
        check("R8 alt_in", alt_in, 8'h00);
        wr_reg(2'd0, 8'h80); wr_reg(2'd1, 8'h80);
        check("R8 still drives", pin_oe & pin_out, 8'h80);
        rd_reg(2'd0, v); check("R8 output read", v, 8'h80);
    endtask

    initial begin
        rst = 1'b1;
        t_reset();
        t_regs();
        t_drive();
        t_preload();
        t_sync();
        t_alt();
        t_analog();
        t_outonly();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule